// File: doc/BRIEF.md
# Programmable Interval Timer Channel

One channel of a three-channel programmable interval timer. A 16-bit presettable down counter decrements in either binary or four-digit BCD. Six counting modes turn the counter's state into a level on the `out` pin: a terminal-count flag, a one-shot, a rate generator, a square wave, and two single-cycle strobes. The `gate` pin either enables counting or acts as a trigger, depending on the mode.

Software programs the channel with a control byte. It then writes a count through staging registers, and the counter picks up that count on a later counter clock. Software can read the live count directly. It can also freeze the count in snapshot latches with a latch command, or freeze a status byte through a read-back command.

The whole channel runs on the system clock `clk`. The counter clock arrives as a one-cycle enable, `tick`, derived from that same clock, so host writes and counting steps always keep a defined order. Address decoding for the control register and the data-bus buffer sit outside this block. They present strobes `cw_we`, `dat_we` and `dat_re` together with the byte on `din`.

Top module: `tmr_channel`

## Requirements
- R1: After the synchronous reset, `out` is 0 and `dout` is 0x00. The stored configuration is binary, mode 0, access code 11.
- R2: A control byte written with `cw_we` is layed out as follows: bits 7:6 select the channel, bits 5:4 give the access code, bits 3:1 give the mode and bit 0 gives BCD. The byte is taken only when bits 7:6 equal the channel number and the access code is non-zero. Mode codes 6 and 7 act as modes 2 and 3. In the cycle after a control byte is taken, `out` is 0 for mode 0 and 1 for every other mode. A control byte aimed at another channel changes nothing.
- R3: The access code selects how `dat_we` and `dat_re` move bytes. Code 01 moves the low byte only, and a write clears the high byte. Code 10 moves the high byte only, and a write clears the low byte. Code 11 moves the low byte and then the high byte, using separate write and read toggles that a control byte resets. A complete count is held in the staging registers and enters the counter on the next `tick`.
- R4: Each counting step subtracts one, in binary or in BCD. A count of 0 is the maximum: it steps to 0xFFFF in binary and to 0x9999 in BCD.
- R5: A latch command is a control byte for this channel with access code 00. It snapshots the count. The snapshot is held until it has been fully read under the current access code. Latch commands that arrive before then are ignored.
- R6: A read-back command has bits 7:6 = 11 and bit (1 + channel number) = 1. Bit 5 = 0 latches the count. Bit 4 = 0 latches a status byte laid out as {out, count-not-yet-loaded, access[1:0], mode[2:0], bcd}. A latched status byte is returned before any latched count. `dout` changes only in the cycle after `dat_re`.
- R7: In mode 0, writing a count drives `out` low. `out` goes high on the N-th counting step after the load and stays high until the channel is written again.
- R8: In mode 1, a written count waits for a rising `gate`. The trigger loads the count and drives `out` low. `out` goes high on the N-th step after the trigger. A later rising edge retriggers the count.
- R9: In mode 2, `out` is low for exactly one step in every N. At the end of each period the counter reloads from the staging registers.
- R10: In mode 3 (N ≥ 2), the counter steps down by two. `out` is high for ceil(N/2) steps and low for floor(N/2) steps, and the counter reloads at each phase change.
- R11: In mode 4, `out` drops for exactly one step, N steps after the count is loaded, and does so only once per load.
- R12: In mode 5, a written count waits for a rising `gate`. `out` drops for one step, N steps after the trigger.
- R13: `gate` low stops counting in modes 0, 2, 3 and 4, and in modes 2 and 3 it also forces `out` high. In modes 2 and 3, a rising `gate` reloads the count. The `gate` level is sampled only on `tick`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter clock enable, one cycle per counting step |
| gate | input | 1 | Gate / trigger level |
| cw_we | input | 1 | Control byte write strobe |
| dat_we | input | 1 | Count byte write strobe |
| dat_re | input | 1 | Data read strobe |
| din | input | 8 | Byte from the host |
| dout | output | 8 | Registered read data |
| out | output | 1 | Timer output pin |

## Verification
The hardest state to reach from the ports is a channel that holds both a latched status byte and a latched count while the counter keeps moving. The bench sets this up by issuing a combined read-back command and then applying further counting steps before reading. It then checks that the status byte comes first and that the frozen count, not the live one, comes back.

Odd-length square waves and retriggering after a gate drop also depend on exact step counts. The bench drives them with directed `tick`/`gate` sequences. Random binary and BCD counts with random step counts exercise digit borrows and wrap-around from zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [1:0] ACC_LATCH = 2'b00;
  localparam logic [1:0] ACC_LO    = 2'b01;
  localparam logic [1:0] ACC_HI    = 2'b10;
  localparam logic [1:0] ACC_PAIR  = 2'b11;

  typedef struct packed {
    logic [1:0] acc;
    logic [2:0] mode;
    logic       bcd;
  } tmr_cfg_t;

  // modes 6 and 7 behave as 2 and 3
  function automatic logic [2:0] fold_mode(input logic [2:0] m);
    return (m[2] & m[1]) ? {1'b0, m[1:0]} : m;
  endfunction
endpackage

// File: rtl/tmr_decr.sv
module tmr_decr #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic         bcd,
  output logic [W-1:0] res
);
  localparam int ND = W / 4;

  logic [ND:0]  brw;
  logic [W-1:0] bcd_res;

  assign brw[0] = 1'b1;

  for (genvar i = 0; i < ND; i++) begin : g_dig
    logic [3:0] nib;
    assign nib = val[4*i +: 4];
    assign bcd_res[4*i +: 4] = !brw[i] ? nib : ((nib == 4'd0) ? 4'd9 : nib - 4'd1);
    assign brw[i+1] = brw[i] & (nib == 4'd0);
  end

  assign res = bcd ? bcd_res : (val - W'(1));
endmodule

// File: rtl/tmr_host.sv
module tmr_host
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CH_ID = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cw_we,
  input  logic             dat_we,
  input  logic             dat_re,
  input  logic [7:0]       din,
  input  logic [CNT_W-1:0] cnt,
  input  logic             out,
  input  logic             load_ack,
  output tmr_cfg_t         cfg,
  output logic [CNT_W-1:0] cr,
  output logic             cw_new,
  output logic [2:0]       new_mode,
  output logic             cnt_wr,
  output logic [7:0]       dout
);
  localparam int BW = 8;

  logic             hit_ch, is_rb, do_latch, st_cap;
  logic [CNT_W-1:0] ol;
  logic             ol_v, st_v, wtg, rtg, nullc;
  logic [7:0]       st;
  logic [CNT_W-1:0] rsrc;
  logic             rd_hi;

  assign hit_ch   = cw_we && (din[7:6] == 2'(CH_ID));
  assign is_rb    = cw_we && (din[7:6] == 2'b11) && din[1+CH_ID];
  assign do_latch = (hit_ch && din[5:4] == ACC_LATCH) || (is_rb && !din[5]);
  assign st_cap   = is_rb && !din[4];
  assign cw_new   = hit_ch && (din[5:4] != ACC_LATCH);
  assign new_mode = fold_mode(din[3:1]);
  assign cnt_wr   = dat_we && ((cfg.acc == ACC_LO) || (cfg.acc == ACC_HI) ||
                               (cfg.acc == ACC_PAIR && wtg));

  assign rsrc  = ol_v ? ol : cnt;
  assign rd_hi = (cfg.acc == ACC_HI) || (cfg.acc == ACC_PAIR && rtg);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg   <= '{acc: ACC_PAIR, mode: 3'd0, bcd: 1'b0};
      cr    <= '0;
      ol    <= '0;
      ol_v  <= 1'b0;
      st    <= '0;
      st_v  <= 1'b0;
      wtg   <= 1'b0;
      rtg   <= 1'b0;
      nullc <= 1'b0;
      dout  <= '0;
    end else begin
      if (load_ack) nullc <= 1'b0;
      if (cw_new) begin
        cfg   <= '{acc: din[5:4], mode: new_mode, bcd: din[0]};
        wtg   <= 1'b0;
        rtg   <= 1'b0;
        nullc <= 1'b1;
      end
      if (do_latch && !ol_v) begin
        ol   <= cnt;
        ol_v <= 1'b1;
      end
      if (st_cap && !st_v) begin
        st   <= {out, nullc, cfg};
        st_v <= 1'b1;
      end
      if (dat_we) begin
        case (cfg.acc)
          ACC_LO: cr <= {{(CNT_W-BW){1'b0}}, din};
          ACC_HI: cr <= {din, {(CNT_W-BW){1'b0}}};
          default: begin
            if (!wtg) cr[BW-1:0] <= din;
            else      cr[CNT_W-1:BW] <= din;
            wtg <= ~wtg;
          end
        endcase
        if (cnt_wr) nullc <= 1'b1;
      end
      if (dat_re) begin
        if (st_v) begin
          dout <= st;
          st_v <= 1'b0;
        end else begin
          dout <= rd_hi ? rsrc[CNT_W-1:BW] : rsrc[BW-1:0];
          if (cfg.acc == ACC_PAIR) rtg <= ~rtg;
          if (ol_v && (cfg.acc != ACC_PAIR || rtg)) ol_v <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             gate,
  input  logic [2:0]       mode,
  input  logic             bcd,
  input  logic [CNT_W-1:0] cr,
  input  logic             cw_new,
  input  logic [2:0]       new_mode,
  input  logic             cnt_wr,
  output logic [CNT_W-1:0] cnt,
  output logic             out,
  output logic             load_ack
);
  localparam logic [CNT_W-1:0] C1 = CNT_W'(1);
  localparam logic [CNT_W-1:0] C2 = CNT_W'(2);
  localparam logic [CNT_W-1:0] C3 = CNT_W'(3);

  logic [CNT_W-1:0] dec1, dec2;
  logic gq, live, pend, armed, strb;
  logic trig, hw_trig, sq_flip;

  tmr_decr #(.W(CNT_W)) u_d1 (.val(cnt),  .bcd(bcd), .res(dec1));
  tmr_decr #(.W(CNT_W)) u_d2 (.val(dec1), .bcd(bcd), .res(dec2));

  assign trig    = gate & ~gq;
  assign hw_trig = trig && ((armed && (mode == 3'd1 || mode == 3'd5)) ||
                            (live  && (mode == 3'd2 || mode == 3'd3)));
  assign sq_flip = (cnt == C2) || (cnt[0] && out && cnt == C1) ||
                   (cnt[0] && !out && cnt == C3);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      out      <= 1'b0;
      gq       <= 1'b0;
      live     <= 1'b0;
      pend     <= 1'b0;
      armed    <= 1'b0;
      strb     <= 1'b0;
      load_ack <= 1'b0;
    end else begin
      load_ack <= 1'b0;
      if (cw_new) begin
        live  <= 1'b0;
        pend  <= 1'b0;
        armed <= 1'b0;
        strb  <= 1'b0;
        out   <= (new_mode != 3'd0);
      end else if (cnt_wr) begin
        case (mode)
          3'd0:       begin out <= 1'b0; live <= 1'b0; pend <= 1'b1; end
          3'd1, 3'd5: armed <= 1'b1;
          3'd2, 3'd3: if (!live) pend <= 1'b1;
          default:    begin live <= 1'b0; pend <= 1'b1; end
        endcase
      end else if (tick) begin
        gq <= gate;
        if (hw_trig || pend) begin
          cnt      <= cr;
          live     <= 1'b1;
          pend     <= 1'b0;
          strb     <= 1'b1;
          load_ack <= 1'b1;
          if (mode != 3'd0) out <= !(hw_trig && mode == 3'd1);
        end else if (live) begin
          case (mode)
            3'd0, 3'd1: if (gate || mode == 3'd1) begin
              cnt <= dec1;
              if (cnt == C1) out <= 1'b1;
            end
            3'd2: if (!gate) out <= 1'b1;
              else if (cnt == C1) begin
                cnt <= cr; out <= 1'b1; load_ack <= 1'b1;
              end else begin
                cnt <= dec1;
                if (cnt == C2) out <= 1'b0;
              end
            3'd3: if (!gate) out <= 1'b1;
              else if (sq_flip) begin
                cnt <= cr; out <= ~out; load_ack <= 1'b1;
              end else cnt <= dec2;
            default: begin
              if (gate || mode == 3'd5) cnt <= dec1;
              if (!out) out <= 1'b1;
              else if (cnt == C1 && strb && (gate || mode == 3'd5)) begin
                out <= 1'b0; strb <= 1'b0;
              end
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CH_ID = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       gate,
  input  logic       cw_we,
  input  logic       dat_we,
  input  logic       dat_re,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       out
);
  tmr_cfg_t         cfg;
  logic [CNT_W-1:0] cr, cnt;
  logic             cw_new, cnt_wr, load_ack;
  logic [2:0]       new_mode, cur_mode;

  assign cur_mode = cfg.mode;

  tmr_host #(.CNT_W(CNT_W), .CH_ID(CH_ID)) u_host (
    .clk(clk), .rst(rst), .cw_we(cw_we), .dat_we(dat_we), .dat_re(dat_re),
    .din(din), .cnt(cnt), .out(out), .load_ack(load_ack), .cfg(cfg),
    .cr(cr), .cw_new(cw_new), .new_mode(new_mode), .cnt_wr(cnt_wr),
    .dout(dout)
  );

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .gate(gate), .mode(cfg.mode),
    .bcd(cfg.bcd), .cr(cr), .cw_new(cw_new), .new_mode(new_mode),
    .cnt_wr(cnt_wr), .cnt(cnt), .out(out), .load_ack(load_ack)
  );
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int CNT_W = 16,
  parameter int CH_ID = 0
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             gate,
  input logic             cw_we,
  input logic             dat_we,
  input logic             dat_re,
  input logic [7:0]       din,
  input logic [7:0]       dout,
  input logic             out,
  input logic [CNT_W-1:0] cnt,
  input logic [2:0]       cur_mode
);
  assert_prog_level_R2: assert property (@(posedge clk) disable iff (rst)
    (cw_we && din[7:6] == 2'(CH_ID) && din[5:4] != 2'b00)
      |=> (out == ($past(din[3:1]) != 3'd0)));

  assert_step_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

  assert_dout_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !dat_re |=> $stable(dout));

  assert_m0_stays_high_R7: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == 3'd0 && out && !cw_we && !dat_we) |=> out);

  assert_gate_low_high_R13: assert property (@(posedge clk) disable iff (rst)
    ((cur_mode == 3'd2 || cur_mode == 3'd3) && tick && !gate && !cw_we && !dat_we)
      |=> out);
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W), .CH_ID(CH_ID)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .gate(gate), .cw_we(cw_we),
  .dat_we(dat_we), .dat_re(dat_re), .din(din), .dout(dout), .out(out),
  .cnt(cnt), .cur_mode(cur_mode)
);

// File: tb/sim_tmr_channel.sv
`timescale 1ns/1ps
module sim_tmr_channel;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, gate = 1'b1;
  logic cw_we = 1'b0, dat_we = 1'b0, dat_re = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic out;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  tmr_channel u0 (.clk(clk), .rst(rst), .tick(tick), .gate(gate), .cw_we(cw_we),
    .dat_we(dat_we), .dat_re(dat_re), .din(din), .dout(dout), .out(out));

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cw(input logic [7:0] b);
    cw_we = 1'b1; din = b; @(negedge clk); cw_we = 1'b0;
  endtask
  task automatic wr(input logic [7:0] b);
    dat_we = 1'b1; din = b; @(negedge clk); dat_we = 1'b0;
  endtask
  task automatic wr16(input logic [15:0] v);
    wr(v[7:0]); wr(v[15:8]);
  endtask
  task automatic rd(output logic [7:0] b);
    dat_re = 1'b1; @(negedge clk); dat_re = 1'b0; b = dout;
  endtask
  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(lo); rd(hi); v = {hi, lo};
  endtask
  task automatic latch16(output logic [15:0] v);
    cw(8'h00); rd16(v);
  endtask
  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
    end
  endtask

  function automatic int bcd2int(input logic [15:0] b);
    int r = 0;
    for (int i = 3; i >= 0; i--) r = r * 10 + int'(b[4*i +: 4]);
    return r;
  endfunction
  function automatic logic [15:0] int2bcd(input int x);
    logic [15:0] r;
    for (int i = 0; i < 4; i++) begin r[4*i +: 4] = 4'(x % 10); x = x / 10; end
    return r;
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v, e;
    logic [7:0] b;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out after reset", out, 0);
    chk("R1 dout after reset", dout, 0);

    // mode 0, binary, pair access
    cw(8'h30);
    chk("R2 mode0 level", out, 0);
    wr16(16'd5);
    cw(8'hE2); rd(b);
    chk("R6 status before load", b, 8'h70);
    tk(1); latch16(v);
    chk("R3 staged count loaded", v, 5);
    tk(4); chk("R7 out still low", out, 0);
    tk(1); chk("R7 out high at N", out, 1);
    wr16(16'd3); chk("R7 write drives low", out, 0);
    tk(1); gate = 1'b0; tk(5); latch16(v);
    chk("R13 gate low holds mode0", v, 3);
    gate = 1'b1; tk(2); chk("R13 resumes", out, 0);
    tk(1); chk("R13 resumes end", out, 1);

    // latch hold
    wr16(16'd100); tk(1); cw(8'h00); tk(10); cw(8'h00); rd16(v);
    chk("R5 snapshot held", v, 100);
    latch16(v); chk("R5 new snapshot", v, 90);

    // random binary and BCD stepping
    for (int i = 0; i < 16; i++) begin
      int k, x;
      k = 1 + int'($urandom % 20);
      if (i[0]) begin
        x = int'($urandom % 10000);
        cw(8'h31); wr16(int2bcd(x)); tk(1 + k); latch16(v);
        e = int2bcd((x - k + 10000) % 10000);
        chk("R4 bcd step", v, e);
      end else begin
        x = int'($urandom % 65536);
        cw(8'h30); wr16(16'(x)); tk(1 + k); latch16(v);
        e = 16'((x - k + 65536) % 65536);
        chk("R4 binary step", v, e);
      end
    end
    cw(8'h30); wr16(16'd0); tk(2); latch16(v);
    chk("R4 binary zero wrap", v, 16'hFFFF);
    cw(8'h31); wr16(16'd0); tk(2); latch16(v);
    chk("R4 bcd zero wrap", v, 16'h9999);

    // single-byte access codes
    cw(8'h10); wr(8'h34); tk(1); rd(b);
    chk("R3 low-only access", b, 8'h34);
    cw(8'h20); wr(8'h12); tk(1); rd(b);
    chk("R3 high-only access", b, 8'h12);

    // mode 1
    cw(8'h32); gate = 1'b0; wr16(16'd3); tk(2);
    chk("R8 waits for trigger", out, 1);
    gate = 1'b1; tk(1); chk("R8 trigger drops out", out, 0);
    tk(2); chk("R8 low before N", out, 0);
    tk(1); chk("R8 high at N", out, 1);
    gate = 1'b0; tk(1); gate = 1'b1; tk(1);
    chk("R8 retrigger", out, 0);

    // mode 2
    cw(8'h34); wr16(16'd4); tk(1);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] p = 8'b11011101;
      tk(1); chk("R9 rate pattern", out, p[7-i]);
    end
    tk(1); gate = 1'b0; tk(3);
    chk("R13 mode2 forced high", out, 1);
    latch16(v); chk("R13 mode2 hold", v, 3);
    gate = 1'b1; tk(1); latch16(v);
    chk("R13 mode2 gate reload", v, 4);

    // mode 3 odd and even
    cw(8'h36); wr16(16'd5); tk(1);
    for (int i = 0; i < 10; i++) begin
      logic [9:0] p = 10'b1100111001;
      tk(1); chk("R10 odd square", out, p[9-i]);
    end
    cw(8'h36); wr16(16'd4); tk(1);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] p = 8'b10011001;
      tk(1); chk("R10 even square", out, p[7-i]);
    end

    // mode 4
    cw(8'h38); wr16(16'd3); tk(1);
    for (int i = 0; i < 5; i++) begin
      logic [4:0] p = 5'b11011;
      tk(1); chk("R11 soft strobe", out, p[4-i]);
    end
    // both latches pending while counting continues
    cw(8'hC2); tk(2); rd(b);
    chk("R6 status first", b, 8'hB8);
    rd16(v); chk("R6 frozen count", v, 16'hFFFE);
    cw(8'h70);
    chk("R2 other channel ignored out", out, 1);
    cw(8'hE2); rd(b);
    chk("R2 other channel ignored cfg", b, 8'hB8);

    // mode 5
    cw(8'h3A); gate = 1'b0; wr16(16'd2); tk(2);
    chk("R12 waits for trigger", out, 1);
    gate = 1'b1; tk(1); chk("R12 after trigger", out, 1);
    tk(1); chk("R12 before strobe", out, 1);
    tk(1); chk("R12 strobe", out, 0);
    tk(1); chk("R12 after strobe", out, 1);

    done = 1;
    summary();
    $finish;
  end
endmodule